// File: doc/BRIEF.md
# SPI Mode Fault Supervisor

This block watches the slave-select input of an SPI port together with the role the port has been given. It raises a sticky mode fault flag whenever the two disagree: a port acting as master sees its select line pulled low, or a port acting as slave sees its select line released while a byte is still being clocked. Slave-side judgement needs to know whether a byte is in progress, so the block tracks byte framing from the select line and the serial clock. The start rule depends on the clock phase setting, and the idle clock level is set by the clock polarity setting.

When a fault is caught in master role, the block emits one-cycle control pulses to the surrounding SPI core. These pulses switch the core off, mark its transmit buffer empty, zero its bit counter and give the pin drivers back to the general-purpose port. The fault flag also feeds a combined error/receive interrupt request. The role input is only read and is never changed, so software can still tell which role was active when the fault occurred.

Top module: `spi_modefault_guard`

## Requirements
- R1: After reset, `fault_flag`, `busy`, `irq_req` and all four side-effect pulse outputs are 0.
- R2: With `spi_en`, `is_master` and `fault_en` high, `ss_n` at 0 sets `fault_flag` on the third rising clock edge after the change, because of a two-stage synchronizer plus the flag register. This holds at any time, not only during a byte.
- R3: In slave role (`is_master`=0) with `spi_en` and `fault_en` high, `ss_n` returning to 1 while `busy` is 1 sets `fault_flag`. `ss_n` going to 1 while `busy` is 0 sets nothing.
- R4: With `cpha`=0 in slave role, `busy` rises on the third clock edge after a falling edge of `ss_n`. It falls after `sck` has returned to its idle level (`sck`==`cpol`) for the eighth time.
- R5: With `cpha`=1 in slave role, a falling `ss_n` alone leaves `busy` at 0. `busy` rises when `sck` leaves its idle level while `ss_n` is 0, and falls after the eighth return of `sck` to idle.
- R6: While `fault_en` is 0 no fault can set `fault_flag`. Lowering `fault_en` leaves a flag that is already set unchanged.
- R7: `irq_req` equals (`fault_flag` AND `err_irq_en`) OR `rx_full_req` OR `overrun_req`, combinationally.
- R8: A master-role fault that takes `fault_flag` from 0 to 1 drives `spi_off_p`, `txe_set_p`, `bitcnt_clr_p` and `pins_release_p` high for exactly that one cycle. A slave-role fault drives none of them.
- R9: A one-cycle `flag_clr` clears `fault_flag` on the next edge. If a fault event is present in the same cycle, the flag stays set.
- R10: While `spi_en` is 0, `busy` is 0 and no fault is detected in either role.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_en | input | 1 | SPI enabled |
| is_master | input | 1 | 1 = master role, 0 = slave role |
| fault_en | input | 1 | Mode fault detection enable |
| err_irq_en | input | 1 | Lets the fault flag drive the interrupt request |
| cpha | input | 1 | Clock phase setting |
| cpol | input | 1 | Idle level of the serial clock |
| ss_n | input | 1 | Slave select pin, active low, asynchronous |
| sck | input | 1 | Serial clock pin, asynchronous |
| flag_clr | input | 1 | One-cycle strobe clearing the fault flag |
| rx_full_req | input | 1 | Receive-full request sharing the interrupt line |
| overrun_req | input | 1 | Overrun request sharing the interrupt line |
| fault_flag | output | 1 | Sticky mode fault flag |
| irq_req | output | 1 | Combined error/receive interrupt request |
| busy | output | 1 | Slave byte in progress |
| spi_off_p | output | 1 | Pulse: clear the SPI enable |
| txe_set_p | output | 1 | Pulse: set the transmit-empty flag |
| bitcnt_clr_p | output | 1 | Pulse: reset the bit state counter |
| pins_release_p | output | 1 | Pulse: return pin direction to the port |

## Verification
Two functions can land in the same cycle: software clearing the flag and the detector raising it again. The bench holds a master in fault with `ss_n` low and the SPI still enabled, then strobes `flag_clr`. The flag must stay set, and the per-cycle reference model, which gives set priority, must agree with the design on every edge. The opposite case is also run. There `spi_en` is dropped first, so no event is present, and the same strobe must clear the flag.

// File: rtl/spi_modefault_guard.sv
module spi_modefault_guard #(
  parameter int BYTE_BITS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_en,
  input  logic is_master,
  input  logic fault_en,
  input  logic err_irq_en,
  input  logic cpha,
  input  logic cpol,
  input  logic ss_n,
  input  logic sck,
  input  logic flag_clr,
  input  logic rx_full_req,
  input  logic overrun_req,
  output logic fault_flag,
  output logic irq_req,
  output logic busy,
  output logic spi_off_p,
  output logic txe_set_p,
  output logic bitcnt_clr_p,
  output logic pins_release_p
);
  localparam int CW = $clog2(BYTE_BITS) + 1;

  logic ss_m, ss_s, ss_d;
  logic ck_m, ck_s, ck_d;
  logic [CW-1:0] edges;
  logic master_pulse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {ss_m, ss_s, ss_d} <= 3'b111;
      {ck_m, ck_s, ck_d} <= 3'b000;
    end else begin
      ss_m <= ss_n;  ss_s <= ss_m;  ss_d <= ss_s;
      ck_m <= sck;   ck_s <= ck_m;  ck_d <= ck_s;
    end
  end

  wire ss_fall   = ss_d & ~ss_s;
  wire sck_lead  = (ck_d == cpol) && (ck_s != cpol);
  wire sck_trail = (ck_d != cpol) && (ck_s == cpol);
  wire start     = cpha ? (sck_lead & ~ss_s) : ss_fall;

  wire mst_evt = spi_en & is_master & fault_en & ~ss_s;
  wire slv_evt = spi_en & ~is_master & fault_en & busy & ss_s;
  wire set_evt = mst_evt | slv_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      edges <= '0;
    end else if (!spi_en || is_master || ss_s) begin
      busy  <= 1'b0;
      edges <= '0;
    end else if (!busy) begin
      busy  <= start;
      edges <= '0;
    end else if (sck_trail) begin
      if (edges == CW'(BYTE_BITS - 1)) begin
        busy  <= 1'b0;
        edges <= '0;
      end else begin
        edges <= edges + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_flag   <= 1'b0;
      master_pulse <= 1'b0;
    end else begin
      master_pulse <= mst_evt & ~fault_flag;
      if (set_evt)       fault_flag <= 1'b1;
      else if (flag_clr) fault_flag <= 1'b0;
    end
  end

  assign irq_req        = (fault_flag & err_irq_en) | rx_full_req | overrun_req;
  assign spi_off_p      = master_pulse;
  assign txe_set_p      = master_pulse;
  assign bitcnt_clr_p   = master_pulse;
  assign pins_release_p = master_pulse;
endmodule

module spi_modefault_guard_chk (
  input logic clk, rst_n, spi_en, fault_en, err_irq_en, flag_clr,
  input logic rx_full_req, overrun_req,
  input logic fault_flag, irq_req, busy,
  input logic spi_off_p, txe_set_p, bitcnt_clr_p, pins_release_p
);
  // R8
  pulse_with_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_off_p |-> (fault_flag && !$past(fault_flag)));
  // R8
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_off_p |=> !spi_off_p);
  // R8
  pulse_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_off_p == txe_set_p) && (txe_set_p == bitcnt_clr_p) && (bitcnt_clr_p == pins_release_p));
  // R6
  no_set_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_en && !fault_flag) |=> !fault_flag);
  // R9
  clear_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !spi_en) |=> !fault_flag);
  // R7
  irq_from_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_flag && err_irq_en) |-> irq_req);
  // R7
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_flag && !rx_full_req && !overrun_req) |-> !irq_req);
  // R10
  idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_en |=> !busy);
endmodule

bind spi_modefault_guard spi_modefault_guard_chk u_chk (.*);

// File: tb/spi_modefault_guard_test.sv
module spi_modefault_guard_test;
  logic clk = 0, rst_n = 0;
  logic spi_en = 0, is_master = 0, fault_en = 0, err_irq_en = 0;
  logic cpha = 0, cpol = 0, ss_n = 1, sck = 0, flag_clr = 0;
  logic rx_full_req = 0, overrun_req = 0;
  logic fault_flag, irq_req, busy, spi_off_p, txe_set_p, bitcnt_clr_p, pins_release_p;

  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  spi_modefault_guard uut (.*);

  // behavioural reference
  bit qss[3], qck[3];
  bit m_busy, m_flag, m_pulse;
  int m_bits;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qss = '{1, 1, 1}; qck = '{0, 0, 0};
      m_busy = 0; m_flag = 0; m_pulse = 0; m_bits = 0;
    end else begin
      bit s_now, s_old, c_now, c_old, mev, sev, lead, trail, nb;
      int nbits;
      s_now = qss[1]; s_old = qss[2]; c_now = qck[1]; c_old = qck[2];
      lead  = (c_old == cpol) && (c_now != cpol);
      trail = (c_old != cpol) && (c_now == cpol);
      mev = spi_en && is_master && fault_en && !s_now;
      sev = spi_en && !is_master && fault_en && m_busy && s_now;
      nb = m_busy; nbits = m_bits;
      if (!spi_en || is_master || s_now) begin nb = 0; nbits = 0; end
      else if (!m_busy) begin
        nb = cpha ? (lead && !s_now) : (s_old && !s_now); nbits = 0;
      end else if (trail) begin
        nbits = m_bits + 1;
        if (nbits == 8) begin nb = 0; nbits = 0; end
      end
      m_pulse = mev && !m_flag;
      if (mev || sev) m_flag = 1; else if (flag_clr) m_flag = 0;
      m_busy = nb; m_bits = nbits;
      qss[2] = qss[1]; qss[1] = qss[0]; qss[0] = ss_n;
      qck[2] = qck[1]; qck[1] = qck[0]; qck[0] = sck;
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #5;
    if (rst_n && !done) begin
      bit mirq;
      mirq = (m_flag && err_irq_en) || rx_full_req || overrun_req;
      chk(fault_flag == m_flag, "model R2/R3/R6/R9 fault_flag", fault_flag, m_flag);
      chk(busy == m_busy, "model R4/R5/R10 busy", busy, m_busy);
      chk(irq_req == mirq, "model R7 irq_req", irq_req, mirq);
      chk(spi_off_p == m_pulse && txe_set_p == m_pulse && bitcnt_clr_p == m_pulse
          && pins_release_p == m_pulse, "model R8 pulses", spi_off_p, m_pulse);
    end
  end

  task automatic edges(input int n); repeat (n) @(posedge clk); #5; endtask
  task automatic drv; @(negedge clk); endtask

  task automatic sck_bit;
    drv; sck = ~cpol; repeat (3) @(negedge clk);
    sck = cpol; repeat (3) @(negedge clk);
  endtask

  task automatic settle; repeat (5) @(negedge clk); endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    edges(1);
    chk(fault_flag == 0 && busy == 0 && irq_req == 0, "R1 reset outputs", fault_flag, 0);
    chk(spi_off_p == 0 && pins_release_p == 0, "R1 reset pulses", spi_off_p, 0);

    // R2 + R8 master fault
    drv; spi_en = 1; is_master = 1; fault_en = 1; err_irq_en = 1;
    settle;
    chk(fault_flag == 0, "R2 no fault while ss_n high", fault_flag, 0);
    drv; ss_n = 0;
    edges(2);
    chk(fault_flag == 0, "R2 flag not yet after two edges", fault_flag, 0);
    edges(1);
    chk(fault_flag == 1, "R2 flag on third edge", fault_flag, 1);
    chk(spi_off_p && txe_set_p && bitcnt_clr_p && pins_release_p, "R8 master pulses high", spi_off_p, 1);
    chk(irq_req == 1, "R7 irq from flag", irq_req, 1);
    edges(1);
    chk(spi_off_p == 0 && pins_release_p == 0, "R8 pulses last one cycle", spi_off_p, 0);

    // R9 set wins over clear while fault persists
    drv; flag_clr = 1; drv; flag_clr = 0;
    edges(1);
    chk(fault_flag == 1, "R9 set wins over clear", fault_flag, 1);
    chk(spi_off_p == 0, "R8 no new pulse when flag already set", spi_off_p, 0);

    // R9 plain clear after core disables SPI
    drv; spi_en = 0;
    drv; flag_clr = 1; drv; flag_clr = 0;
    edges(0);
    chk(fault_flag == 0, "R9 clear strobe", fault_flag, 0);
    drv; err_irq_en = 0;

    // R6 fault_en low blocks setting
    drv; spi_en = 1; fault_en = 0;
    settle;
    chk(fault_flag == 0, "R6 no set with fault_en low", fault_flag, 0);
    drv; fault_en = 1; settle;
    chk(fault_flag == 1, "R6 set when enabled", fault_flag, 1);
    drv; fault_en = 0; spi_en = 0; ss_n = 1; settle;
    chk(fault_flag == 1, "R6 lowering fault_en keeps flag", fault_flag, 1);
    drv; flag_clr = 1; drv; flag_clr = 0; settle;
    chk(fault_flag == 0, "R6 cleared flag stays clear", fault_flag, 0);

    // R7 shared requests
    drv; rx_full_req = 1; edges(0);
    chk(irq_req == 1, "R7 rx_full_req drives irq", irq_req, 1);
    drv; rx_full_req = 0; overrun_req = 1; edges(0);
    chk(irq_req == 1, "R7 overrun_req drives irq", irq_req, 1);
    drv; overrun_req = 0; edges(0);
    chk(irq_req == 0, "R7 irq quiet", irq_req, 0);

    // R3 slave aborted byte, cpha 0 cpol 0
    drv; is_master = 0; fault_en = 1; spi_en = 1; cpha = 0; cpol = 0; sck = 0; settle;
    drv; ss_n = 0;
    edges(2);
    chk(busy == 0, "R4 busy not before third edge", busy, 0);
    edges(1);
    chk(busy == 1, "R4 busy after ss_n falls", busy, 1);
    for (int i = 0; i < 7; i++) sck_bit;
    chk(busy == 1, "R4 still busy after seven bits", busy, 1);
    drv; ss_n = 1; settle;
    chk(fault_flag == 1, "R3 slave abort sets flag", fault_flag, 1);
    chk(busy == 0, "R3 busy dropped", busy, 0);
    drv; flag_clr = 1; drv; flag_clr = 0; settle;

    // R4 full byte then release: no fault
    drv; ss_n = 0; settle;
    for (int i = 0; i < 7; i++) sck_bit;
    drv; sck = 1; repeat (3) @(negedge clk);
    sck = 0; edges(2);
    chk(busy == 1, "R4 busy until sync of eighth return", busy, 1);
    edges(1);
    chk(busy == 0, "R4 end after eighth return to idle", busy, 0);
    drv; ss_n = 1; settle;
    chk(fault_flag == 0, "R3 release outside byte sets nothing", fault_flag, 0);

    // R5 cpha 1 cpol 1
    drv; cpha = 1; cpol = 1; sck = 1; settle;
    drv; ss_n = 0; settle;
    chk(busy == 0, "R5 ss_n fall alone does not start", busy, 0);
    drv; sck = 0; settle;
    chk(busy == 1, "R5 start on sck leaving idle", busy, 1);
    drv; sck = 1; repeat (3) @(negedge clk);
    for (int i = 0; i < 7; i++) sck_bit;
    settle;
    chk(busy == 0, "R5 end after eighth return", busy, 0);
    drv; ss_n = 1; settle;
    chk(fault_flag == 0, "R5 release after byte no fault", fault_flag, 0);

    // R10 disabled: no framing, no fault
    drv; spi_en = 0; cpha = 0; ss_n = 0; settle;
    chk(busy == 0, "R10 no busy when disabled", busy, 0);
    sck_bit;
    drv; ss_n = 1; settle;
    chk(fault_flag == 0, "R10 no slave fault when disabled", fault_flag, 0);
    drv; is_master = 1; ss_n = 0; settle;
    chk(fault_flag == 0, "R10 no master fault when disabled", fault_flag, 0);
    chk(spi_off_p == 0, "R8 slave/disabled gives no pulse", spi_off_p, 0);

    settle;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule